// File: doc/BRIEF.md
# Daisy-Chainable Serial Configuration Register

This block is the serial configuration port of a two-channel frequency synthesizer core. A 21-bit shift register takes one bit per rising edge of the interface clock while the load strobe is low. The most significant bit comes first, so the last two bits shifted in sit at the bottom of the register. Those two bits form an address. The 19 bits above them are the payload. A rising edge on the load strobe copies the payload into one of four holding registers. The holding registers drive the divider settings of the two channels: the reference divider R and the main-divider values M, A and F.

A single output pin serves two purposes. By default it passes an external lock-detect signal through. A control bit written with the channel-2 main-divider word switches the pin to serial data-out. In that mode the pin shows the top bit of the shift register, updated on the falling edge of the clock. The next device in a chain then samples a stable bit on the following rising edge. Chained devices therefore behave as a single long shift register, with exactly 21 clocks between neighbours.

Top module: `serial_cfg_reg`

## Requirements
- R1: While `le_i` is low, each rising edge of `clk_i` shifts the register up one place and puts `sdata_i` into bit 0. A 21-bit word is sent starting from its bit 20, so after 21 shifts register bit k equals word bit k.
- R2: In data-out mode, `sout_o` equals shift-register bit 20 as sampled at the most recent falling edge of `clk_i`. It does not change at the rising edge.
- R3: Register bits [1:0] are the address. Bits [20:2] are the payload, and payload bit p is register bit p+2.
- R4: Address 2'b00 loads `ch1_r_o` from payload[8:0].
- R5: Address 2'b01 loads `ch1_m_o` from payload[18:10], `ch1_a_o` from payload[9:5] and `ch1_f_o` from payload[4:0].
- R6: Address 2'b10 loads `ch2_r_o` from payload[8:0].
- R7: Address 2'b11 loads the output-select bit from payload[18], `ch2_m_o` from payload[17:9], `ch2_a_o` from payload[8:5] and `ch2_f_o` from payload[4:0]. An output-select value of 1 means data-out and 0 means lock-detect.
- R8: A holding register changes only on the clock edge where `le_i` is high after being low. Shifting without such an edge leaves every divider output unchanged. While `le_i` stays high, the shift register holds its contents.
- R9: With output-select 0, `sout_o` follows `lock_i`. With output-select 1, `sout_o` ignores `lock_i`.
- R10: While `rst_ni` is low, every R and M output is 3, every A and F output is 0, the output-select bit is 0 and the shift register is cleared.
- R11: When two devices are chained (the second device's `sdata_i` driven by the first device's `sout_o`, with the first in data-out mode and `le_i` shared), a bit reaches the second device's register 21 clocks after it enters the first. One load pulse after 42 shifts loads the last word into the first device and the word before it into the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Serial interface clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial data in, sampled on rising edge |
| le_i | input | 1 | Load strobe; low to shift, rising edge loads |
| lock_i | input | 1 | Lock-detect signal for the shared output |
| sout_o | output | 1 | Shared output: lock-detect or serial data-out |
| ch1_r_o | output | 9 | Channel 1 reference divider |
| ch1_m_o | output | 9 | Channel 1 main divider M |
| ch1_a_o | output | 5 | Channel 1 swallow count A |
| ch1_f_o | output | 5 | Channel 1 fraction F |
| ch2_r_o | output | 9 | Channel 2 reference divider |
| ch2_m_o | output | 9 | Channel 2 main divider M |
| ch2_a_o | output | 4 | Channel 2 swallow count A |
| ch2_f_o | output | 5 | Channel 2 fraction F |

## Verification
The assertions run on every cycle. They check the shift step and the freeze while the strobe is high. They check that each address loads its own fields from the payload of the previous cycle, and that the outputs stay stable when there is no load edge. They also check the output multiplexer in both modes and the reset values. Some behaviour is only visible in the bench scenarios, because it spans two devices or needs the exact edge timing. That covers the 21-clock delay through a chain of two devices, the half-cycle timing of data-out (the value before and after the falling edge), and the MSB-first order of whole words. The bench covers these with sweeps of all four addresses, including all-zero and all-one payloads.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int SR_W    = 21;
  localparam int ADDR_W  = 2;
  localparam int PAY_W   = SR_W - ADDR_W;
  localparam int DIV_W   = 9;
  localparam int A1_W    = 5;
  localparam int A2_W    = 4;
  localparam int FR_W    = 5;
  localparam int DIV_MIN = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CH1_R   = 2'b00,
    ADDR_CH1_MAF = 2'b01,
    ADDR_CH2_R   = 2'b10,
    ADDR_CH2_MAF = 2'b11
  } cfg_addr_e;
endpackage

// File: rtl/serial_cfg_shift.sv
module serial_cfg_shift
  import serial_cfg_pkg::*;
#(
  parameter int W = SR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sdata_i,
  input  logic         le_i,
  output logic [W-1:0] shift_o,
  output logic         sout_o,
  output logic         load_o
);
  logic le_q;

  // reset le_q high so a strobe held through reset is not taken as an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_o <= '0;
      le_q    <= 1'b1;
    end else begin
      le_q <= le_i;
      if (!le_i) shift_o <= {shift_o[W-2:0], sdata_i};
    end
  end

  // top bit launched on the falling edge for the next device in a chain
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sout_o <= 1'b0;
    else         sout_o <= shift_o[W-1];
  end

  assign load_o = le_i & ~le_q;
endmodule

// File: rtl/serial_cfg_chan.sv
module serial_cfg_chan
  import serial_cfg_pkg::*;
#(
  parameter int        A_W      = A1_W,
  parameter cfg_addr_e R_ADDR   = ADDR_CH1_R,
  parameter cfg_addr_e MAF_ADDR = ADDR_CH1_MAF,
  localparam int       MAF_W    = DIV_W + A_W + FR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  cfg_addr_e        addr_i,
  input  logic [DIV_W-1:0] r_i,
  input  logic [MAF_W-1:0] maf_i,
  output logic [DIV_W-1:0] r_o,
  output logic [DIV_W-1:0] m_o,
  output logic [A_W-1:0]   a_o,
  output logic [FR_W-1:0]  f_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_o <= DIV_W'(DIV_MIN);
      m_o <= DIV_W'(DIV_MIN);
      a_o <= '0;
      f_o <= '0;
    end else begin
      if (load_i && addr_i == R_ADDR)   r_o <= r_i;
      if (load_i && addr_i == MAF_ADDR) {m_o, a_o, f_o} <= maf_i;
    end
  end
endmodule

// File: rtl/serial_cfg_reg.sv
module serial_cfg_reg
  import serial_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             le_i,
  input  logic             lock_i,
  output logic             sout_o,
  output logic [DIV_W-1:0] ch1_r_o,
  output logic [DIV_W-1:0] ch1_m_o,
  output logic [A1_W-1:0]  ch1_a_o,
  output logic [FR_W-1:0]  ch1_f_o,
  output logic [DIV_W-1:0] ch2_r_o,
  output logic [DIV_W-1:0] ch2_m_o,
  output logic [A2_W-1:0]  ch2_a_o,
  output logic [FR_W-1:0]  ch2_f_o
);
  localparam int MAF1_W = DIV_W + A1_W + FR_W;
  localparam int MAF2_W = DIV_W + A2_W + FR_W;

  logic [SR_W-1:0]  shift_w;
  logic [PAY_W-1:0] payload_w;
  cfg_addr_e        addr_w;
  logic             sout_w;
  logic             load_w;
  logic             out_sel_q;

  serial_cfg_shift #(.W(SR_W)) shift_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sdata_i (sdata_i),
    .le_i    (le_i),
    .shift_o (shift_w),
    .sout_o  (sout_w),
    .load_o  (load_w)
  );

  assign payload_w = shift_w[SR_W-1:ADDR_W];
  assign addr_w    = cfg_addr_e'(shift_w[ADDR_W-1:0]);

  serial_cfg_chan #(.A_W(A1_W), .R_ADDR(ADDR_CH1_R), .MAF_ADDR(ADDR_CH1_MAF)) ch1_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .addr_i (addr_w),
    .r_i    (payload_w[DIV_W-1:0]),
    .maf_i  (payload_w[MAF1_W-1:0]),
    .r_o    (ch1_r_o),
    .m_o    (ch1_m_o),
    .a_o    (ch1_a_o),
    .f_o    (ch1_f_o)
  );

  serial_cfg_chan #(.A_W(A2_W), .R_ADDR(ADDR_CH2_R), .MAF_ADDR(ADDR_CH2_MAF)) ch2_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .addr_i (addr_w),
    .r_i    (payload_w[DIV_W-1:0]),
    .maf_i  (payload_w[MAF2_W-1:0]),
    .r_o    (ch2_r_o),
    .m_o    (ch2_m_o),
    .a_o    (ch2_a_o),
    .f_o    (ch2_f_o)
  );

  // output select rides in the top payload bit of the channel-2 main word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 out_sel_q <= 1'b0;
    else if (load_w && addr_w == ADDR_CH2_MAF)   out_sel_q <= payload_w[PAY_W-1];
  end

  assign sout_o = out_sel_q ? sout_w : lock_i;
endmodule

// File: rtl/serial_cfg_reg_chk.sv
module serial_cfg_reg_chk
  import serial_cfg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sdata_i,
  input logic             le_i,
  input logic             lock_i,
  input logic             sout_o,
  input logic [SR_W-1:0]  shift_w,
  input logic             load_w,
  input logic             out_sel_q,
  input logic [DIV_W-1:0] ch1_r_o,
  input logic [DIV_W-1:0] ch1_m_o,
  input logic [A1_W-1:0]  ch1_a_o,
  input logic [FR_W-1:0]  ch1_f_o,
  input logic [DIV_W-1:0] ch2_r_o,
  input logic [DIV_W-1:0] ch2_m_o,
  input logic [A2_W-1:0]  ch2_a_o,
  input logic [FR_W-1:0]  ch2_f_o
);
  a_r1_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_i |=> shift_w == {$past(shift_w[SR_W-2:0]), $past(sdata_i)});

  a_r8_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> $stable(shift_w));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_w |=> $stable({ch1_r_o, ch1_m_o, ch1_a_o, ch1_f_o, ch2_r_o, ch2_m_o,
                         ch2_a_o, ch2_f_o, out_sel_q}));

  a_r4_ch1_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_w && shift_w[ADDR_W-1:0] == 2'b00) |=> ch1_r_o == $past(shift_w[ADDR_W+DIV_W-1:ADDR_W]));

  a_r5_ch1_maf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_w && shift_w[ADDR_W-1:0] == 2'b01) |=>
      {ch1_m_o, ch1_a_o, ch1_f_o} == $past(shift_w[SR_W-1:ADDR_W]));

  a_r6_ch2_r: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_w && shift_w[ADDR_W-1:0] == 2'b10) |=> ch2_r_o == $past(shift_w[ADDR_W+DIV_W-1:ADDR_W]));

  a_r7_ch2_maf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_w && shift_w[ADDR_W-1:0] == 2'b11) |=>
      {out_sel_q, ch2_m_o, ch2_a_o, ch2_f_o} == $past(shift_w[SR_W-1:ADDR_W]));

  a_r2_data_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sel_q |-> sout_o == shift_w[SR_W-1]);

  a_r9_lock_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_sel_q |-> sout_o == lock_i);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r10_reset: assert (ch1_r_o == DIV_W'(DIV_MIN) && ch1_m_o == DIV_W'(DIV_MIN) &&
                           ch2_r_o == DIV_W'(DIV_MIN) && ch2_m_o == DIV_W'(DIV_MIN) &&
                           ch1_a_o == '0 && ch1_f_o == '0 && ch2_a_o == '0 &&
                           ch2_f_o == '0 && !out_sel_q && shift_w == '0);
    end
  end
endmodule

bind serial_cfg_reg serial_cfg_reg_chk chk_i (.*);

// File: tb/serial_cfg_reg_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_reg_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, sdata, le, lock;
  logic sout1, sout2;
  logic [8:0] c1r, c1m, c2r, c2m, d2_c1r, d2_c1m, d2_c2r, d2_c2m;
  logic [4:0] c1a, c1f, c2f, d2_c1a, d2_c1f, d2_c2f;
  logic [3:0] c2a, d2_c2a;

  serial_cfg_reg dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata), .le_i(le), .lock_i(lock),
    .sout_o(sout1), .ch1_r_o(c1r), .ch1_m_o(c1m), .ch1_a_o(c1a), .ch1_f_o(c1f),
    .ch2_r_o(c2r), .ch2_m_o(c2m), .ch2_a_o(c2a), .ch2_f_o(c2f));

  serial_cfg_reg dut2_i (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sout1), .le_i(le), .lock_i(lock),
    .sout_o(sout2), .ch1_r_o(d2_c1r), .ch1_m_o(d2_c1m), .ch1_a_o(d2_c1a), .ch1_f_o(d2_c1f),
    .ch2_r_o(d2_c2r), .ch2_m_o(d2_c2m), .ch2_a_o(d2_c2a), .ch2_f_o(d2_c2f));

  int n_chk = 0;
  int n_fail = 0;
  logic [20:0] mdl;
  logic [8:0] e1r, e1m, e2r, e2m;
  logic [4:0] e1a, e1f, e2f;
  logic [3:0] e2a;
  logic       esel;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic drive_bit(input logic b, input bit so_chk);
    logic old;
    sdata = b;
    @(posedge clk);
    old = mdl[20];
    mdl = {mdl[19:0], b};
    #1;
    if (so_chk) chk(sout1 == old, "R2 before falling edge", sout1, old);
    @(negedge clk);
    #1;
    if (so_chk) chk(sout1 == mdl[20], "R2 after falling edge", sout1, mdl[20]);
  endtask

  task automatic shift_word(input logic [20:0] w, input bit so_chk);
    for (int i = 20; i >= 0; i--) drive_bit(w[i], so_chk);
  endtask

  task automatic pulse_le();
    le = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    le = 1'b0;
  endtask

  task automatic model_load(input logic [20:0] w);
    logic [18:0] p;
    p = w[20:2];
    case (w[1:0])
      2'b00: e1r = p[8:0];
      2'b01: begin e1m = p[18:10]; e1a = p[9:5]; e1f = p[4:0]; end
      2'b10: e2r = p[8:0];
      default: begin esel = p[18]; e2m = p[17:9]; e2a = p[8:5]; e2f = p[4:0]; end
    endcase
  endtask

  task automatic check_all(input string req);
    chk(c1r == e1r, {req, " ch1_r"}, c1r, e1r);
    chk(c1m == e1m, {req, " ch1_m"}, c1m, e1m);
    chk(c1a == e1a, {req, " ch1_a"}, c1a, e1a);
    chk(c1f == e1f, {req, " ch1_f"}, c1f, e1f);
    chk(c2r == e2r, {req, " ch2_r"}, c2r, e2r);
    chk(c2m == e2m, {req, " ch2_m"}, c2m, e2m);
    chk(c2a == e2a, {req, " ch2_a"}, c2a, e2a);
    chk(c2f == e2f, {req, " ch2_f"}, c2f, e2f);
  endtask

  initial begin
    #(200000 * 5.0);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [20:0] w;
    logic [18:0] pay;
    logic [20:0] wa, wb;
    rst_ni = 1'b1; sdata = 1'b0; le = 1'b0; lock = 1'b0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R10: reset values
    e1r = 9'd3; e1m = 9'd3; e2r = 9'd3; e2m = 9'd3;
    e1a = '0; e1f = '0; e2a = '0; e2f = '0; esel = 1'b0;
    check_all("R10");
    lock = 1'b1;
    #1 chk(sout1 == 1'b1, "R10 output select resets to lock", sout1, 1);
    lock = 1'b0;
    rst_ni = 1'b1;
    mdl = '0;

    // R1/R3..R7: sweep of all addresses, zero, all-one and mixed payloads
    for (int i = 0; i < 40; i++) begin
      if (i < 4)      pay = '0;
      else if (i < 8) pay = '1;
      else            pay = 19'((i * 40503 + 12345) & 19'h7FFFF);
      if (i % 4 == 3) pay[18] = 1'b0;
      w = {pay, 2'(i % 4)};
      shift_word(w, 0);
      pulse_le();
      model_load(w);
      case (i % 4)
        0: check_all("R1/R3/R4");
        1: check_all("R1/R3/R5");
        2: check_all("R1/R3/R6");
        default: check_all("R1/R3/R7");
      endcase
    end

    // R8: shifting a whole word without a load edge changes nothing
    shift_word({19'h5A5A5, 2'b01}, 0);
    shift_word({19'h1F0F0, 2'b10}, 0);
    check_all("R8 no load edge");

    // R9: lock-detect passes through while select is 0
    for (int v = 0; v < 2; v++) begin
      lock = v[0];
      #1 chk(sout1 == v[0], "R9 lock pass-through", sout1, v);
    end

    // R7/R9: set output select to data-out
    w = {1'b1, 9'd7, 4'd2, 5'd9, 2'b11};
    shift_word(w, 0);
    pulse_le();
    model_load(w);
    check_all("R7 select word");
    chk(sout1 == mdl[20], "R7/R9 data-out selected", sout1, mdl[20]);
    lock = ~mdl[20];
    #1 chk(sout1 == mdl[20], "R9 lock ignored in data-out", sout1, mdl[20]);

    // R2: half-cycle timing of data-out on every bit
    shift_word({19'h6B2D3, 2'b00}, 1);

    // R8: strobe held high freezes the register (load happens once)
    le = 1'b1;
    for (int k = 0; k < 4; k++) begin
      sdata = k[0];
      @(posedge clk);
      @(negedge clk);
      #1 chk(sout1 == mdl[20], "R8 shift frozen while strobe high", sout1, mdl[20]);
    end
    le = 1'b0;
    model_load(mdl);
    check_all("R8 single load");
    drive_bit(1'b0, 1);

    // R11: chain of two devices, 21-clock offset
    wa = {10'h0, 9'h1C7, 2'b00};
    wb = {10'h0, 9'h0D2, 2'b10};
    shift_word(wa, 0);
    shift_word(wb, 0);
    pulse_le();
    model_load(wb);
    check_all("R11 first device");
    chk(d2_c1r == 9'h1C7, "R11 second device ch1_r", d2_c1r, 9'h1C7);

    wa = {9'd300, 5'd17, 5'd21, 2'b01};
    wb = {10'h0, 9'h123, 2'b00};
    shift_word(wa, 0);
    shift_word(wb, 0);
    pulse_le();
    model_load(wb);
    check_all("R11 first device");
    chk(d2_c1m == 9'd300, "R11 second device ch1_m", d2_c1m, 300);
    chk(d2_c1a == 5'd17, "R11 second device ch1_a", d2_c1a, 17);
    chk(d2_c1f == 5'd21, "R11 second device ch1_f", d2_c1f, 21);
    chk(d2_c1r == 9'h1C7, "R11 second device ch1_r kept", d2_c1r, 9'h1C7);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule